// File: doc/BRIEF.md
# NAND Flash Block Erase Sequencer

This block is the host-side engine that erases one block of an 8-bit asynchronous NAND flash device. The surrounding logic presents a block number with a one-cycle request. The sequencer then runs the whole exchange on the flash bus without further help. It sends the erase-setup command, then the two row-address bytes, then the erase-go command. After that it waits for the device to finish and reads the status byte to learn whether the erase worked. It ends with a one-cycle done pulse, and the result flags stay valid until the next request.

Every strobe on the bus is measured in clock cycles. A parameter sets each of these intervals: how long the latch-enable lines are set up before write-enable falls, how long write-enable stays low, how long the latch lines are held after write-enable rises, and how long read-enable stays low. Completion is detected in one of two ways, picked at build time. In the first, the sequencer watches the ready/busy line (after a synchronizer) and issues one status read once the device is ready. In the second, it sends the status command once and then re-reads the status byte at a fixed interval until the ready bit is set. A timeout counter guards the wait. When busy lasts too long, the sequencer sends the device reset command and reports a timeout.

Top module: `nand_erase_seq`

## Requirements
- R1: After reset and while idle: chip enable, write enable and read enable are high (inactive), CLE and ALE are low, the write-protect output is low (protected), the data bus is not driven, and `busy` is low.
- R2: The first bus cycle of an erase carries command byte 60h. CLE is high and ALE is low at the rising edge of write enable.
- R3: Exactly two address cycles (ALE high) follow the setup command. The row address is the block number shifted left by 6, so the 6 page bits are zero. The first byte is {block[1:0], 6'b0} and the second byte is block[9:2].
- R4: After the second address byte comes command byte D0h, latched with CLE high.
- R5: Write enable stays low for exactly WE_LO_CYC clocks. CLE or ALE is high for at least SETUP_CYC clocks before write enable falls, and stays steady across the rising edge.
- R6: The write-protect output is high for the whole operation, from the cycle after the request until done.
- R7: In ready/busy mode (COMPLETE_BY_RB=1), the status command 70h is not sent while the device holds ready/busy low.
- R8: In status-polling mode (COMPLETE_BY_RB=0), 70h is sent once. The status byte is then re-read every POLL_GAP clocks until bit 6 is 1.
- R9: `done` is a single-cycle pulse. When the erase finishes normally, `fail` equals bit 0 of the last status byte (0 = pass) and `timeout` is 0.
- R10: If the wait lasts more than TIMEOUT_CYC clocks after the erase-go command, the sequencer sends reset command FFh. It then pulses `done` with `timeout`=1 and `fail`=1.
- R11: While waiting for the erase to finish, the only command bytes sent are 70h and FFh.
- R12: A request that arrives while `busy` is high is ignored. The erase in progress keeps its block address and no second erase starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle erase request |
| req_block | input | BLK_W | Block number to erase |
| busy | output | 1 | Erase sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Erase failed or timed out (held until next request) |
| timeout | output | 1 | Device stayed busy past the limit (held until next request) |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_wp_n | output | 1 | Write protect, active low |
| nand_rb_n | input | 1 | Ready (high) / busy (low) from the device |
| nand_io_in | input | 8 | Data bus from the device |
| nand_io_out | output | 8 | Data bus to the device |
| nand_io_oe | output | 1 | Drive enable for nand_io_out |

## Verification
A write cycle on the bus takes SETUP_CYC + WE_LO_CYC + HOLD_CYC clocks. One idle clock follows before the next cycle starts. A status read takes SETUP_CYC + RE_LO_CYC + HOLD_CYC clocks, and `done` rises one clock after the last read ends. The bench drives inputs and samples outputs on the falling clock edge. A behavioural device model counts write-enable low clocks and setup clocks at every strobe, so the timing requirements are checked at every latch and not only at the end. Result flags are read in the cycle where `done` is seen, and `done` is read again one clock later to confirm the pulse width. Because the ready/busy path has a two-flop synchronizer, the bench waits for completion with a bounded loop and does not count a fixed delay.

// File: rtl/nand_erase_pkg.sv
package nand_erase_pkg;

  typedef enum logic [1:0] {
    BUS_CMD  = 2'd0,
    BUS_ADDR = 2'd1,
    BUS_READ = 2'd2
  } bus_kind_e;

  typedef enum logic [3:0] {
    SQ_IDLE     = 4'd0,
    SQ_SETUP    = 4'd1,
    SQ_ROW_LO   = 4'd2,
    SQ_ROW_HI   = 4'd3,
    SQ_GO       = 4'd4,
    SQ_GAP      = 4'd5,
    SQ_WAIT_RB  = 4'd6,
    SQ_STAT_CMD = 4'd7,
    SQ_STAT_RD  = 4'd8,
    SQ_RESET    = 4'd9,
    SQ_FINISH   = 4'd10
  } seq_state_e;

  localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
  localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
  localparam logic [7:0] OP_STATUS      = 8'h70;
  localparam logic [7:0] OP_RESET       = 8'hFF;

  localparam logic [7:0] ST_READY_MASK  = 8'h40;
  localparam logic [7:0] ST_FAIL_MASK   = 8'h01;

  localparam int PAGE_BITS = 6;

endpackage

// File: rtl/nand_bus_cycle.sv
module nand_bus_cycle
  import nand_erase_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int WE_LO_CYC = 3,
  parameter int HOLD_CYC  = 2,
  parameter int RE_LO_CYC = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  input  bus_kind_e kind_i,
  input  logic [7:0] wr_byte_i,
  input  logic [7:0] io_in_i,
  output logic      done_o,
  output logic [7:0] rd_byte_o,
  output logic      cle_o,
  output logic      ale_o,
  output logic      we_n_o,
  output logic      re_n_o,
  output logic [7:0] io_out_o,
  output logic      io_oe_o
);

  localparam int MAX_AB = (SETUP_CYC > WE_LO_CYC) ? SETUP_CYC : WE_LO_CYC;
  localparam int MAX_CD = (HOLD_CYC > RE_LO_CYC) ? HOLD_CYC : RE_LO_CYC;
  localparam int MAX_C  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CW     = $clog2(MAX_C + 1);

  localparam logic [CW-1:0] SETUP_LD = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] WE_LD    = CW'(WE_LO_CYC - 1);
  localparam logic [CW-1:0] RE_LD    = CW'(RE_LO_CYC - 1);
  localparam logic [CW-1:0] HOLD_LD  = CW'(HOLD_CYC - 1);

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  bus_kind_e     kind_q, kind_d;
  logic [7:0]    byte_q, byte_d;
  logic [7:0]    rd_q, rd_d;
  logic          is_read;

  assign is_read = (kind_q == BUS_READ);

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    kind_d = kind_q;
    byte_d = byte_q;
    rd_d   = rd_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (start_i) begin
          ph_d   = PH_SETUP;
          cnt_d  = SETUP_LD;
          kind_d = kind_i;
          byte_d = wr_byte_i;
        end
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          ph_d  = PH_STROBE;
          cnt_d = is_read ? RE_LD : WE_LD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_STROBE: begin
        if (cnt_q == '0) begin
          ph_d  = PH_HOLD;
          cnt_d = HOLD_LD;
          if (is_read) rd_d = io_in_i;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_HOLD: begin
        if (cnt_q == '0) ph_d = PH_IDLE;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      kind_q <= BUS_CMD;
      byte_q <= '0;
      rd_q   <= '0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      kind_q <= kind_d;
      byte_q <= byte_d;
      rd_q   <= rd_d;
    end
  end

  assign done_o    = (ph_q == PH_HOLD) && (cnt_q == '0);
  assign rd_byte_o = rd_q;
  assign cle_o     = (ph_q != PH_IDLE) && (kind_q == BUS_CMD);
  assign ale_o     = (ph_q != PH_IDLE) && (kind_q == BUS_ADDR);
  assign we_n_o    = !((ph_q == PH_STROBE) && !is_read);
  assign re_n_o    = !((ph_q == PH_STROBE) && is_read);
  assign io_out_o  = byte_q;
  assign io_oe_o   = (ph_q != PH_IDLE) && !is_read;

  // Checker-only: length of the current write-enable low pulse.
  logic [CW:0] we_lo_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       we_lo_run <= '0;
    else if (!we_n_o) we_lo_run <= we_lo_run + 1'b1;
    else              we_lo_run <= '0;
  end

  // R5
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n_o) |-> (we_lo_run == (CW+1)'(WE_LO_CYC)));

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n_o) |-> ($stable(cle_o) && $stable(ale_o) && (cle_o || ale_o)));

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n_o) |-> re_n_o && $past(cle_o || ale_o));

endmodule

// File: rtl/nand_wait_timer.sv
module nand_wait_timer #(
  parameter int TIMEOUT_CYC = 100000,
  parameter int POLL_GAP    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic gap_start_i,
  output logic gap_done_o,
  output logic expired_o
);

  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam int GW = $clog2(POLL_GAP + 1);
  localparam logic [TW-1:0] T_LIMIT = TW'(TIMEOUT_CYC);
  localparam logic [GW-1:0] G_LOAD  = GW'(POLL_GAP - 1);

  logic [TW-1:0] tcnt_q, tcnt_d;
  logic [GW-1:0] gcnt_q, gcnt_d;
  logic          armed_q, armed_d;

  always_comb begin
    tcnt_d = tcnt_q;
    if (!run_i)                tcnt_d = '0;
    else if (tcnt_q != T_LIMIT) tcnt_d = tcnt_q + 1'b1;
  end

  always_comb begin
    gcnt_d  = gcnt_q;
    armed_d = armed_q;
    if (gap_start_i) begin
      gcnt_d  = G_LOAD;
      armed_d = 1'b1;
    end else if (armed_q) begin
      if (gcnt_q == '0) armed_d = 1'b0;
      else              gcnt_d  = gcnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q  <= '0;
      gcnt_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      tcnt_q  <= tcnt_d;
      gcnt_q  <= gcnt_d;
      armed_q <= armed_d;
    end
  end

  assign expired_o  = run_i && (tcnt_q == T_LIMIT);
  assign gap_done_o = armed_q && (gcnt_q == '0);

  // R8
  gap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_done_o && !gap_start_i) |=> !gap_done_o);

endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq
  import nand_erase_pkg::*;
#(
  parameter int BLK_W          = 10,
  parameter int SETUP_CYC      = 2,
  parameter int WE_LO_CYC      = 3,
  parameter int HOLD_CYC       = 2,
  parameter int RE_LO_CYC      = 3,
  parameter int POLL_GAP       = 8,
  parameter int TIMEOUT_CYC    = 100000,
  parameter bit COMPLETE_BY_RB = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [BLK_W-1:0] req_block,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic             timeout,
  output logic             nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic             nand_wp_n,
  input  logic             nand_rb_n,
  input  logic [7:0]       nand_io_in,
  output logic [7:0]       nand_io_out,
  output logic             nand_io_oe
);

  localparam int ROW_W = BLK_W + PAGE_BITS;

  seq_state_e       state_q, state_d;
  logic             go_q, go_d;
  logic [BLK_W-1:0] blk_q, blk_d;
  logic             fail_q, fail_d;
  logic             tmo_q, tmo_d;
  logic             sent_q, sent_d;
  logic             wait_q, wait_d;
  logic             gap_start;
  logic             rb_meta, rb_s;

  logic             cyc_done;
  logic [7:0]       rd_byte;
  bus_kind_e        cyc_kind;
  logic [7:0]       cyc_byte;
  logic             gap_done, expired;
  logic [ROW_W-1:0] row_addr;
  logic             st_ready, st_fail;

  assign row_addr = {blk_q, {PAGE_BITS{1'b0}}};
  assign st_ready = |(rd_byte & ST_READY_MASK);
  assign st_fail  = |(rd_byte & ST_FAIL_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_meta <= 1'b0;
      rb_s    <= 1'b0;
    end else begin
      rb_meta <= nand_rb_n;
      rb_s    <= rb_meta;
    end
  end

  always_comb begin
    cyc_kind = BUS_CMD;
    cyc_byte = 8'h00;
    unique case (state_q)
      SQ_SETUP:    cyc_byte = OP_ERASE_SETUP;
      SQ_ROW_LO: begin
        cyc_kind = BUS_ADDR;
        cyc_byte = row_addr[7:0];
      end
      SQ_ROW_HI: begin
        cyc_kind = BUS_ADDR;
        cyc_byte = 8'(row_addr[ROW_W-1:8]);
      end
      SQ_GO:       cyc_byte = OP_ERASE_GO;
      SQ_STAT_CMD: cyc_byte = OP_STATUS;
      SQ_STAT_RD:  cyc_kind = BUS_READ;
      SQ_RESET:    cyc_byte = OP_RESET;
      default:     cyc_byte = 8'h00;
    endcase
  end

  always_comb begin
    state_d   = state_q;
    go_d      = 1'b0;
    blk_d     = blk_q;
    fail_d    = fail_q;
    tmo_d     = tmo_q;
    sent_d    = sent_q;
    wait_d    = wait_q;
    gap_start = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (req_valid) begin
          state_d = SQ_SETUP;
          go_d    = 1'b1;
          blk_d   = req_block;
          fail_d  = 1'b0;
          tmo_d   = 1'b0;
          sent_d  = 1'b0;
        end
      end
      SQ_SETUP: if (cyc_done) begin
        state_d = SQ_ROW_LO;
        go_d    = 1'b1;
      end
      SQ_ROW_LO: if (cyc_done) begin
        state_d = SQ_ROW_HI;
        go_d    = 1'b1;
      end
      SQ_ROW_HI: if (cyc_done) begin
        state_d = SQ_GO;
        go_d    = 1'b1;
      end
      SQ_GO: if (cyc_done) begin
        state_d   = SQ_GAP;
        gap_start = 1'b1;
        wait_d    = 1'b1;
      end
      SQ_GAP: begin
        if (expired) begin
          state_d = SQ_RESET;
          go_d    = 1'b1;
        end else if (gap_done) begin
          go_d = 1'b1;
          if (COMPLETE_BY_RB) begin
            state_d = SQ_WAIT_RB;
            go_d    = 1'b0;
          end else if (sent_q) begin
            state_d = SQ_STAT_RD;
          end else begin
            state_d = SQ_STAT_CMD;
          end
        end
      end
      SQ_WAIT_RB: begin
        if (expired) begin
          state_d = SQ_RESET;
          go_d    = 1'b1;
        end else if (rb_s) begin
          state_d = SQ_STAT_CMD;
          go_d    = 1'b1;
        end
      end
      SQ_STAT_CMD: if (cyc_done) begin
        state_d = SQ_STAT_RD;
        go_d    = 1'b1;
        sent_d  = 1'b1;
      end
      SQ_STAT_RD: if (cyc_done) begin
        if (st_ready) begin
          state_d = SQ_FINISH;
          fail_d  = st_fail;
          wait_d  = 1'b0;
        end else if (expired) begin
          state_d = SQ_RESET;
          go_d    = 1'b1;
        end else begin
          state_d   = SQ_GAP;
          gap_start = 1'b1;
        end
      end
      SQ_RESET: if (cyc_done) begin
        state_d = SQ_FINISH;
        tmo_d   = 1'b1;
        fail_d  = 1'b1;
        wait_d  = 1'b0;
      end
      SQ_FINISH: state_d = SQ_IDLE;
      default:   state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      go_q    <= 1'b0;
      blk_q   <= '0;
      fail_q  <= 1'b0;
      tmo_q   <= 1'b0;
      sent_q  <= 1'b0;
      wait_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      go_q    <= go_d;
      blk_q   <= blk_d;
      fail_q  <= fail_d;
      tmo_q   <= tmo_d;
      sent_q  <= sent_d;
      wait_q  <= wait_d;
    end
  end

  nand_bus_cycle #(
    .SETUP_CYC (SETUP_CYC),
    .WE_LO_CYC (WE_LO_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .RE_LO_CYC (RE_LO_CYC)
  ) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (go_q),
    .kind_i    (cyc_kind),
    .wr_byte_i (cyc_byte),
    .io_in_i   (nand_io_in),
    .done_o    (cyc_done),
    .rd_byte_o (rd_byte),
    .cle_o     (nand_cle),
    .ale_o     (nand_ale),
    .we_n_o    (nand_we_n),
    .re_n_o    (nand_re_n),
    .io_out_o  (nand_io_out),
    .io_oe_o   (nand_io_oe)
  );

  nand_wait_timer #(
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .POLL_GAP    (POLL_GAP)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (wait_q),
    .gap_start_i (gap_start),
    .gap_done_o  (gap_done),
    .expired_o   (expired)
  );

  assign busy      = (state_q != SQ_IDLE);
  assign done      = (state_q == SQ_FINISH);
  assign fail      = fail_q;
  assign timeout   = tmo_q;
  assign nand_ce_n = (state_q == SQ_IDLE);
  assign nand_wp_n = (state_q != SQ_IDLE);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  wp_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nand_we_n) |-> nand_wp_n);

  // R10
  timeout_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && timeout) |-> fail);

  // R11
  wait_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && nand_cle && !nand_we_n) |->
      (nand_io_out == OP_STATUS || nand_io_out == OP_RESET));

  // R7
  rb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (COMPLETE_BY_RB && nand_cle && !nand_we_n && nand_io_out == OP_STATUS) |-> rb_s);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (nand_we_n && nand_re_n && !nand_io_oe));

endmodule

// File: tb/nand_erase_seq_test.sv
module nand_die_model #(
  parameter int WE_LO     = 3,
  parameter int SETUP_MIN = 2
) (
  input  logic       clk,
  input  logic       clr,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  input  logic       re_n,
  input  logic       wp_n,
  input  logic [7:0] io,
  input  int         busy_len,
  input  logic       fail_in,
  output logic       rb_n,
  output logic [7:0] io_rd,
  output logic [31:0] seq,
  output int         n_erase,
  output int         n_stat,
  output int         n_stat_busy,
  output int         n_reads,
  output int         n_reset,
  output int         n_bad,
  output int         n_wp,
  output int         n_tim
);
  int   busy_cnt, lo_cnt, set_cnt, idx;
  logic prev_we, prev_re, st_fail;

  always_ff @(posedge clk) begin
    prev_we <= we_n;
    prev_re <= re_n;
    if (clr) begin
      busy_cnt <= 0; lo_cnt <= 0; set_cnt <= 0; idx <= 0; st_fail <= 1'b0;
      seq <= '0; n_erase <= 0; n_stat <= 0; n_stat_busy <= 0; n_reads <= 0;
      n_reset <= 0; n_bad <= 0; n_wp <= 0; n_tim <= 0;
    end else begin
      if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
      if (!we_n) lo_cnt <= lo_cnt + 1;
      if (!(cle || ale)) set_cnt <= 0;
      else if (we_n && prev_we) set_cnt <= set_cnt + 1;
      if (prev_we && !we_n && set_cnt < SETUP_MIN) n_tim <= n_tim + 1;
      if (prev_re && !re_n) n_reads <= n_reads + 1;
      if (!prev_we && we_n) begin
        lo_cnt  <= 0;
        set_cnt <= 0;
        if (lo_cnt != WE_LO) n_tim <= n_tim + 1;
        if (!wp_n) n_wp <= n_wp + 1;
        if (cle || ale) begin
          if (idx < 4) begin
            seq[idx*8 +: 8] <= io;
            idx <= idx + 1;
          end
        end
        if (cle) begin
          if (busy_cnt > 0 && io != 8'h70 && io != 8'hFF) n_bad <= n_bad + 1;
          case (io)
            8'h60: n_erase <= n_erase + 1;
            8'hD0: begin busy_cnt <= busy_len; st_fail <= fail_in; end
            8'h70: begin
              n_stat <= n_stat + 1;
              if (busy_cnt > 0) n_stat_busy <= n_stat_busy + 1;
            end
            8'hFF: begin n_reset <= n_reset + 1; busy_cnt <= 0; end
            default: ;
          endcase
        end
      end
    end
  end

  assign rb_n  = (busy_cnt == 0);
  assign io_rd = !re_n ? {1'b1, rb_n, rb_n, 4'b0000, st_fail} : 8'h00;
endmodule

module nand_erase_seq_test;
  localparam int WE_LO = 3;
  localparam int SETUP = 2;
  localparam int GAP   = 8;
  localparam int TMO   = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       req_v [2];
  logic [9:0] req_blk;
  logic       busy_w [2], done_w [2], fail_w [2], tmo_w [2];
  logic       ce_n [2], cle [2], ale [2], we_n [2], re_n [2], wp_n [2], rb_n [2], oe [2];
  logic [7:0] io_o [2], io_i [2];
  int         blen [2];
  logic       fin [2];
  logic       clr;
  logic [31:0] seq [2];
  int n_erase [2], n_stat [2], n_sb [2], n_rd [2], n_rst [2], n_bad [2], n_wp [2], n_tim [2];

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  nand_erase_seq #(.SETUP_CYC(SETUP), .WE_LO_CYC(WE_LO), .HOLD_CYC(2), .RE_LO_CYC(3),
    .POLL_GAP(GAP), .TIMEOUT_CYC(TMO), .COMPLETE_BY_RB(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_v[0]), .req_block(req_blk),
    .busy(busy_w[0]), .done(done_w[0]), .fail(fail_w[0]), .timeout(tmo_w[0]),
    .nand_ce_n(ce_n[0]), .nand_cle(cle[0]), .nand_ale(ale[0]), .nand_we_n(we_n[0]),
    .nand_re_n(re_n[0]), .nand_wp_n(wp_n[0]), .nand_rb_n(rb_n[0]), .nand_io_in(io_i[0]),
    .nand_io_out(io_o[0]), .nand_io_oe(oe[0]));

  nand_erase_seq #(.SETUP_CYC(SETUP), .WE_LO_CYC(WE_LO), .HOLD_CYC(2), .RE_LO_CYC(3),
    .POLL_GAP(GAP), .TIMEOUT_CYC(TMO), .COMPLETE_BY_RB(1'b0)) uut_poll (
    .clk(clk), .rst_n(rst_n), .req_valid(req_v[1]), .req_block(req_blk),
    .busy(busy_w[1]), .done(done_w[1]), .fail(fail_w[1]), .timeout(tmo_w[1]),
    .nand_ce_n(ce_n[1]), .nand_cle(cle[1]), .nand_ale(ale[1]), .nand_we_n(we_n[1]),
    .nand_re_n(re_n[1]), .nand_wp_n(wp_n[1]), .nand_rb_n(rb_n[1]), .nand_io_in(io_i[1]),
    .nand_io_out(io_o[1]), .nand_io_oe(oe[1]));

  nand_die_model #(.WE_LO(WE_LO), .SETUP_MIN(SETUP)) dev0 (
    .clk(clk), .clr(clr), .cle(cle[0]), .ale(ale[0]), .we_n(we_n[0]), .re_n(re_n[0]),
    .wp_n(wp_n[0]), .io(io_o[0]), .busy_len(blen[0]), .fail_in(fin[0]), .rb_n(rb_n[0]),
    .io_rd(io_i[0]), .seq(seq[0]), .n_erase(n_erase[0]), .n_stat(n_stat[0]),
    .n_stat_busy(n_sb[0]), .n_reads(n_rd[0]), .n_reset(n_rst[0]), .n_bad(n_bad[0]),
    .n_wp(n_wp[0]), .n_tim(n_tim[0]));

  nand_die_model #(.WE_LO(WE_LO), .SETUP_MIN(SETUP)) dev1 (
    .clk(clk), .clr(clr), .cle(cle[1]), .ale(ale[1]), .we_n(we_n[1]), .re_n(re_n[1]),
    .wp_n(wp_n[1]), .io(io_o[1]), .busy_len(blen[1]), .fail_in(fin[1]), .rb_n(rb_n[1]),
    .io_rd(io_i[1]), .seq(seq[1]), .n_erase(n_erase[1]), .n_stat(n_stat[1]),
    .n_stat_busy(n_sb[1]), .n_reads(n_rd[1]), .n_reset(n_rst[1]), .n_bad(n_bad[1]),
    .n_wp(n_wp[1]), .n_tim(n_tim[1]));

  // {block[9:0], busy_len[15:0], fail}
  localparam logic [26:0] VEC [5] = '{
    {10'h000, 16'd40,  1'b0},
    {10'h3FF, 16'd120, 1'b1},
    {10'h155, 16'd60,  1'b0},
    {10'h2AA, 16'd250, 1'b1},
    {10'h001, 16'd20,  1'b0}
  };

  task automatic check(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic start_erase(input int d, input logic [9:0] blk, input int busy, input logic f);
    blen[d] = busy;
    fin[d]  = f;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    req_blk  = blk;
    req_v[d] = 1'b1;
    @(negedge clk);
    req_v[d] = 1'b0;
  endtask

  task automatic wait_done(input int d);
    bit got = 0;
    for (int i = 0; i < 20000; i++) begin
      if (done_w[d]) begin got = 1; break; end
      @(negedge clk);
    end
    check(got, "R9 done seen", got, 1);
  endtask

  task automatic check_frame(input int d, input logic [9:0] blk);
    check(seq[d][7:0] == 8'h60, "R2 setup cmd", seq[d][7:0], 8'h60);
    check(seq[d][15:8] == {blk[1:0], 6'b0}, "R3 row byte 1", seq[d][15:8], {blk[1:0], 6'b0});
    check(seq[d][23:16] == blk[9:2], "R3 row byte 2", seq[d][23:16], blk[9:2]);
    check(seq[d][31:24] == 8'hD0, "R4 go cmd", seq[d][31:24], 8'hD0);
    check(n_tim[d] == 0, "R5 strobe timing", n_tim[d], 0);
    check(n_wp[d] == 0, "R6 wp high at strobes", n_wp[d], 0);
    check(n_bad[d] == 0, "R11 cmd while busy", n_bad[d], 0);
  endtask

  task automatic check_done_pulse(input int d);
    @(negedge clk);
    check(!done_w[d], "R9 done one cycle", done_w[d], 0);
    check(!busy_w[d], "R1 idle after done", busy_w[d], 0);
    check(!wp_n[d], "R1 wp low when idle", wp_n[d], 0);
  endtask

  initial begin
    req_v[0] = 1'b0; req_v[1] = 1'b0; req_blk = '0; clr = 1'b1;
    blen[0] = 0; blen[1] = 0; fin[0] = 1'b0; fin[1] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    clr = 1'b0;
    @(negedge clk);

    for (int d = 0; d < 2; d++) begin
      check(ce_n[d] && we_n[d] && re_n[d], "R1 strobes idle", {ce_n[d], we_n[d], re_n[d]}, 3'b111);
      check(!cle[d] && !ale[d] && !oe[d], "R1 latches and bus idle", {cle[d], ale[d], oe[d]}, 0);
      check(!wp_n[d] && !busy_w[d], "R1 protected and not busy", {wp_n[d], busy_w[d]}, 0);
    end

    for (int v = 0; v < 5; v++) begin
      for (int d = 0; d < 2; d++) begin
        start_erase(d, VEC[v][26:17], int'(VEC[v][16:1]), VEC[v][0]);
        check(wp_n[d] && busy_w[d], "R6 wp raised with busy", {wp_n[d], busy_w[d]}, 2'b11);
        wait_done(d);
        check(fail_w[d] == VEC[v][0], "R9 fail from status bit 0", fail_w[d], VEC[v][0]);
        check(!tmo_w[d], "R9 no timeout", tmo_w[d], 0);
        check(n_rst[d] == 0, "R10 no reset on normal end", n_rst[d], 0);
        if (d == 0) check(n_sb[d] == 0, "R7 no status while rb low", n_sb[d], 0);
        check_frame(d, VEC[v][26:17]);
        check_done_pulse(d);
      end
    end

    // R8: polling mode with a long erase
    start_erase(1, 10'h0F0, 300, 1'b0);
    wait_done(1);
    check(n_stat[1] == 1, "R8 status cmd issued once", n_stat[1], 1);
    check(n_rd[1] >= 2, "R8 repeated status reads", n_rd[1], 2);
    check(!fail_w[1], "R8 pass after polling", fail_w[1], 0);
    check_done_pulse(1);

    // R7: ready/busy mode reads status once, after ready
    start_erase(0, 10'h0F0, 300, 1'b0);
    wait_done(0);
    check(n_stat[0] == 1 && n_rd[0] == 1, "R7 single status read", {n_stat[0][7:0], n_rd[0][7:0]}, 16'h0101);
    check_done_pulse(0);

    // R10: timeout on both modes
    for (int d = 0; d < 2; d++) begin
      start_erase(d, 10'h123, 5000, 1'b0);
      wait_done(d);
      check(tmo_w[d] && fail_w[d], "R10 timeout and fail", {tmo_w[d], fail_w[d]}, 2'b11);
      check(n_rst[d] == 1, "R10 reset cmd sent", n_rst[d], 1);
      check(n_bad[d] == 0, "R11 only status/reset while busy", n_bad[d], 0);
      check_done_pulse(d);
    end

    // R12: request during busy is ignored
    for (int d = 0; d < 2; d++) begin
      start_erase(d, 10'h2C3, 200, 1'b1);
      repeat (60) @(negedge clk);
      req_blk  = 10'h011;
      req_v[d] = 1'b1;
      @(negedge clk);
      req_v[d] = 1'b0;
      wait_done(d);
      check(n_erase[d] == 1, "R12 single erase", n_erase[d], 1);
      check(seq[d][23:16] == 8'hB0, "R12 address kept", seq[d][23:16], 8'hB0);
      check(fail_w[d], "R12 result of first erase", fail_w[d], 1);
      check_done_pulse(d);
      repeat (40) @(negedge clk);
      check(n_erase[d] == 1 && !busy_w[d], "R12 no late start", n_erase[d], 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule